// File: doc/BRIEF.md
# Dual Cascadable Interval Timer

Two identical down-counting interval timers are configured together through one control word. Each timer keeps its own reload divider, run/stop-and-load mode and clock source, and each raises a sticky interrupt when it passes zero. Clock sources are single-cycle enable strobes that arrive in the system clock domain: a slow tick (a 19.2 kHz rate, for example) and a fast tick (a 6.25 MHz rate, for example).

The second timer can take the first timer's underflow pulse as its clock. The two 8-bit counters then act as one 16-bit counter, and the combined value can be read as a single word. A divider of 192 on a 19.2 kHz tick gives the classic 100 Hz system tick. Every control write updates both timers, so software has to rewrite the field of the timer it does not mean to change.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset both counts read 0, both interrupts are low and both timers are stopped: strobes on either tick input change no count.
- R2: A write whose mode bit (field bit 9) is 0 stops that timer and loads divider−1 into its count, where a divider field of 0 loads 255 (period 256). While stopped the count holds.
- R3: While running (mode bit 1), each strobe of the selected source (field bits 11:10: 0 = slow tick, 1 = fast tick) lowers the count by one. Strobes of an unselected source are ignored.
- R4: A selected strobe that arrives while the count is 0 reloads divider−1 on that same edge and sets the timer's interrupt flag, which shows on its interrupt output after that edge.
- R5: The interrupt flag is sticky. Writing 1 to the clear bit (field bit 8) clears it. Writing 0 leaves it unchanged. If an underflow falls in the same cycle as a clear, the flag stays set.
- R6: With source code 2, timer 1 steps once per timer 0 underflow. The combined output is {timer 1 count, timer 0 count}. The chain period is the product of the two dividers.
- R7: Source code 3 stops counting for either timer. Timer 0 treats code 2 the same way, since it has no cascade input.
- R8: A divider of 192 on the slow tick gives exactly one underflow every 192 strobes.
- R9: A write that keeps a timer running does not disturb its current count. A new divider takes effect at the next reload.

Control word layout: timer 0 uses bits 11:0 and timer 1 uses bits 23:12. Within each field, bits 7:0 hold the divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 24 | Control word, two 12-bit timer fields |
| tick_slow | input | 1 | Slow source enable strobe |
| tick_fast | input | 1 | Fast source enable strobe |
| cnt0_o | output | 8 | Timer 0 count |
| cnt1_o | output | 8 | Timer 1 count |
| cnt_chain_o | output | 16 | Combined count, timer 1 in the upper byte |
| irq0_o | output | 1 | Timer 0 interrupt level |
| irq1_o | output | 1 | Timer 1 interrupt level |

## Verification
The assertions assume that a count changes only through a load by a control write, a one-step decrement or a reload from zero. They also assume that an interrupt can fall only in the cycle after a write with a clear bit set. This holds only if every tick input is a clean one-cycle strobe, and the stimulus ensures it: strobes and writes are driven on the falling clock edge and each lasts exactly one cycle. Apart from the set-versus-clear case, which exercises that collision on purpose, the bench never places a strobe in the same cycle as a control write. This keeps each expected count independent of ordering inside a single write cycle.

// File: rtl/dit_pkg.sv
package dit_pkg;
  // Clock source codes held in field bits [11:10].
  typedef enum logic [1:0] {
    SRC_SLOW  = 2'd0,
    SRC_FAST  = 2'd1,
    SRC_CHAIN = 2'd2,
    SRC_OFF   = 2'd3
  } src_e;

  // Bits in a timer field beyond the divider: clear, run, two source bits.
  localparam int CTRL_EXTRA = 4;
endpackage

// File: rtl/dit_tick_sel.sv
module dit_tick_sel
  import dit_pkg::*;
#(
  parameter bit CASC_EN = 1'b0
) (
  input  src_e sel,
  input  logic tick_slow,
  input  logic tick_fast,
  input  logic tick_casc,
  output logic tick_o
);
  always_comb begin
    case (sel)
      SRC_SLOW:  tick_o = tick_slow;
      SRC_FAST:  tick_o = tick_fast;
      SRC_CHAIN: tick_o = CASC_EN ? tick_casc : 1'b0;
      default:   tick_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/dit_timer.sv
module dit_timer
  import dit_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter bit CASC_EN = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_div,
  input  logic             wr_clr,
  input  logic             wr_run,
  input  src_e             wr_sel,
  input  logic             tick_slow,
  input  logic             tick_fast,
  input  logic             tick_casc,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_o,
  output logic             uflow_o
);
  logic [CNT_W-1:0] div_q, cnt_q;
  logic             run_q, flag_q, src_tick, step;
  src_e             sel_q;

  dit_tick_sel #(.CASC_EN(CASC_EN)) u_sel (
    .sel      (sel_q),
    .tick_slow(tick_slow),
    .tick_fast(tick_fast),
    .tick_casc(tick_casc),
    .tick_o   (src_tick)
  );

  assign step    = run_q & src_tick;
  assign uflow_o = step & (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= '0;
      run_q  <= 1'b0;
      sel_q  <= SRC_SLOW;
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (wr_en) begin
        div_q <= wr_div;
        run_q <= wr_run;
        sel_q <= wr_sel;
      end
      // Divider-1 wraps, so a divider of 0 gives a period of 2**CNT_W.
      if (wr_en && !wr_run)
        cnt_q <= wr_div - CNT_W'(1);
      else if (uflow_o)
        cnt_q <= div_q - CNT_W'(1);
      else if (step)
        cnt_q <= cnt_q - CNT_W'(1);
      // A set takes priority over a clear in the same cycle.
      if (uflow_o)
        flag_q <= 1'b1;
      else if (wr_en && wr_clr)
        flag_q <= 1'b0;
    end
  end

  assign count_o = cnt_q;
  assign irq_o   = flag_q;
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
  import dit_pkg::*;
#(
  parameter  int CNT_W   = 8,
  localparam int FIELD_W = CNT_W + CTRL_EXTRA,
  localparam int CTRL_W  = 2 * FIELD_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ctrl_we,
  input  logic [CTRL_W-1:0]  ctrl_wdata,
  input  logic               tick_slow,
  input  logic               tick_fast,
  output logic [CNT_W-1:0]   cnt0_o,
  output logic [CNT_W-1:0]   cnt1_o,
  output logic [2*CNT_W-1:0] cnt_chain_o,
  output logic               irq0_o,
  output logic               irq1_o
);
  localparam int NTMR = 2;

  logic [CNT_W-1:0] cnt [NTMR];
  logic             irq [NTMR];
  logic             uf  [NTMR];

  for (genvar i = 0; i < NTMR; i++) begin : g_tmr
    localparam int B = i * FIELD_W;
    dit_timer #(.CNT_W(CNT_W), .CASC_EN(i == 1)) u_tmr (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (ctrl_we),
      .wr_div   (ctrl_wdata[B +: CNT_W]),
      .wr_clr   (ctrl_wdata[B + CNT_W]),
      .wr_run   (ctrl_wdata[B + CNT_W + 1]),
      .wr_sel   (src_e'(ctrl_wdata[B + CNT_W + 2 +: 2])),
      .tick_slow(tick_slow),
      .tick_fast(tick_fast),
      .tick_casc((i == 0) ? 1'b0 : uf[0]),
      .count_o  (cnt[i]),
      .irq_o    (irq[i]),
      .uflow_o  (uf[i])
    );
  end

  assign cnt0_o      = cnt[0];
  assign cnt1_o      = cnt[1];
  assign cnt_chain_o = {cnt[1], cnt[0]};
  assign irq0_o      = irq[0];
  assign irq1_o      = irq[1];
endmodule

// File: rtl/dit_checker.sv
module dit_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             ctrl_we,
  input logic             clr0_bit,
  input logic             clr1_bit,
  input logic [CNT_W-1:0] cnt0_o,
  input logic [CNT_W-1:0] cnt1_o,
  input logic             irq0_o,
  input logic             irq1_o
);
  // R1: reset leaves zero counts and no interrupt
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (cnt0_o == '0 && cnt1_o == '0 && !irq0_o && !irq1_o));

  // R3: without a write, a nonzero count only steps down by one
  a_r3_step0: assert property (@(posedge clk) disable iff (rst)
    (!$past(ctrl_we) && $past(cnt0_o) != '0 && cnt0_o != $past(cnt0_o))
      |-> cnt0_o == $past(cnt0_o) - CNT_W'(1));
  a_r3_step1: assert property (@(posedge clk) disable iff (rst)
    (!$past(ctrl_we) && $past(cnt1_o) != '0 && cnt1_o != $past(cnt1_o))
      |-> cnt1_o == $past(cnt1_o) - CNT_W'(1));

  // R4: an interrupt rises only out of a zero count
  a_r4_rise0: assert property (@(posedge clk) disable iff (rst)
    $rose(irq0_o) |-> $past(cnt0_o) == '0);
  a_r4_rise1: assert property (@(posedge clk) disable iff (rst)
    $rose(irq1_o) |-> $past(cnt1_o) == '0);

  // R5: an interrupt falls only after a write with the clear bit set
  a_r5_clear0: assert property (@(posedge clk) disable iff (rst)
    $fell(irq0_o) |-> $past(ctrl_we && clr0_bit));
  a_r5_clear1: assert property (@(posedge clk) disable iff (rst)
    $fell(irq1_o) |-> $past(ctrl_we && clr1_bit));
endmodule

bind dual_interval_timer dit_checker #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .ctrl_we (ctrl_we),
  .clr0_bit(ctrl_wdata[CNT_W]),
  .clr1_bit(ctrl_wdata[FIELD_W + CNT_W]),
  .cnt0_o  (cnt0_o),
  .cnt1_o  (cnt1_o),
  .irq0_o  (irq0_o),
  .irq1_o  (irq1_o)
);

// File: tb/dual_interval_timer_tb.sv
module dual_interval_timer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctrl_we = 1'b0;
  logic [23:0] ctrl_wdata = '0;
  logic        tick_slow = 1'b0;
  logic        tick_fast = 1'b0;
  logic [7:0]  cnt0_o, cnt1_o;
  logic [15:0] cnt_chain_o;
  logic        irq0_o, irq1_o;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dual_interval_timer u_dut (
    .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .tick_slow(tick_slow), .tick_fast(tick_fast),
    .cnt0_o(cnt0_o), .cnt1_o(cnt1_o), .cnt_chain_o(cnt_chain_o),
    .irq0_o(irq0_o), .irq1_o(irq1_o)
  );

  // Timer 1 parked in stop mode with divider 0 (count 255).
  localparam logic [11:0] T1_PARK = 12'h000;

  function automatic logic [11:0] fld(input logic [7:0] dv, input logic clr,
                                      input logic run, input logic [1:0] src);
    return {src, run, clr, dv};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] f1, input logic [11:0] f0);
    @(negedge clk);
    ctrl_we = 1'b1; ctrl_wdata = {f1, f0};
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic pulse(input bit fast, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (fast) tick_fast = 1'b1; else tick_slow = 1'b1;
      @(negedge clk);
      tick_fast = 1'b0; tick_slow = 1'b0;
    end
  endtask

  task automatic t_reset();
    chk("R1 cnt0", {8'h0, cnt0_o}, 16'h0);
    chk("R1 chain", cnt_chain_o, 16'h0);
    chk("R1 irq", {14'h0, irq1_o, irq0_o}, 16'h0);
    pulse(0, 3); pulse(1, 3);
    chk("R1 stopped", cnt_chain_o, 16'h0);
  endtask

  task automatic t_load();
    wr(T1_PARK, fld(8'd10, 0, 0, 2'd0));
    chk("R2 load div10", {8'h0, cnt0_o}, 16'd9);
    chk("R2 load div0", {8'h0, cnt1_o}, 16'd255);
    pulse(0, 2); pulse(1, 2);
    chk("R2 hold stopped", cnt_chain_o, 16'hFF09);
  endtask

  task automatic t_run_select();
    wr(T1_PARK, fld(8'd10, 0, 1, 2'd1));
    chk("R3 run write keeps count", {8'h0, cnt0_o}, 16'd9);
    pulse(0, 3);
    chk("R3 unselected ignored", {8'h0, cnt0_o}, 16'd9);
    pulse(1, 4);
    chk("R3 fast steps", {8'h0, cnt0_o}, 16'd5);
  endtask

  task automatic t_underflow();
    pulse(1, 5);
    chk("R4 at zero", {8'h0, cnt0_o}, 16'd0);
    chk("R4 no irq yet", {15'h0, irq0_o}, 16'd0);
    pulse(1, 1);
    chk("R4 reload", {8'h0, cnt0_o}, 16'd9);
    chk("R4 irq set", {15'h0, irq0_o}, 16'd1);
    pulse(1, 3);
    chk("R5 sticky", {15'h0, irq0_o}, 16'd1);
    wr(T1_PARK, fld(8'd10, 0, 1, 2'd1));
    chk("R5 noop keeps", {15'h0, irq0_o}, 16'd1);
    wr(T1_PARK, fld(8'd10, 1, 1, 2'd1));
    chk("R5 clear", {15'h0, irq0_o}, 16'd0);
    chk("R5 clear keeps count", {8'h0, cnt0_o}, 16'd6);
  endtask

  task automatic t_set_wins();
    pulse(1, 6);
    chk("R5 pre zero", {8'h0, cnt0_o}, 16'd0);
    @(negedge clk);
    ctrl_we = 1'b1; ctrl_wdata = {T1_PARK, fld(8'd10, 1, 1, 2'd1)}; tick_fast = 1'b1;
    @(negedge clk);
    ctrl_we = 1'b0; tick_fast = 1'b0;
    chk("R5 set wins", {15'h0, irq0_o}, 16'd1);
    chk("R5 set wins reload", {8'h0, cnt0_o}, 16'd9);
    wr(T1_PARK, fld(8'd10, 1, 1, 2'd1));
    chk("R5 cleared after", {15'h0, irq0_o}, 16'd0);
  endtask

  task automatic t_sel_off();
    wr(T1_PARK, fld(8'd10, 0, 1, 2'd3));
    pulse(0, 2); pulse(1, 2);
    chk("R7 code3 halts", {8'h0, cnt0_o}, 16'd9);
    wr(T1_PARK, fld(8'd10, 0, 1, 2'd2));
    pulse(0, 2); pulse(1, 2);
    chk("R7 code2 on timer0 halts", {8'h0, cnt0_o}, 16'd9);
  endtask

  task automatic t_div_change();
    wr(T1_PARK, fld(8'd5, 0, 0, 2'd1));
    chk("R9 load", {8'h0, cnt0_o}, 16'd4);
    wr(T1_PARK, fld(8'd5, 0, 1, 2'd1));
    pulse(1, 2);
    chk("R9 counting", {8'h0, cnt0_o}, 16'd2);
    wr(T1_PARK, fld(8'd7, 0, 1, 2'd1));
    chk("R9 count undisturbed", {8'h0, cnt0_o}, 16'd2);
    pulse(1, 3);
    chk("R9 new divider on reload", {8'h0, cnt0_o}, 16'd6);
  endtask

  task automatic t_hundred();
    wr(T1_PARK, fld(8'd192, 1, 0, 2'd0));
    wr(T1_PARK, fld(8'd192, 0, 1, 2'd0));
    pulse(0, 191);
    chk("R8 191 strobes", {7'h0, irq0_o, cnt0_o}, 16'd0);
    pulse(0, 1);
    chk("R8 192nd strobe", {7'h0, irq0_o, cnt0_o}, {7'h0, 1'b1, 8'd191});
    wr(T1_PARK, fld(8'd192, 1, 1, 2'd0));
    pulse(0, 191);
    chk("R8 second period early", {15'h0, irq0_o}, 16'd0);
    pulse(0, 1);
    chk("R8 second period", {15'h0, irq0_o}, 16'd1);
  endtask

  task automatic t_cascade();
    wr(fld(8'd3, 1, 0, 2'd2), fld(8'd4, 1, 0, 2'd1));
    chk("R6 loaded", cnt_chain_o, 16'h0203);
    wr(fld(8'd3, 0, 1, 2'd2), fld(8'd4, 0, 1, 2'd1));
    pulse(0, 3);
    chk("R6 slow ignored", cnt_chain_o, 16'h0203);
    pulse(1, 5);
    chk("R6 chain after 5", cnt_chain_o, 16'h0102);
    chk("R6 irq0 after 5", {15'h0, irq0_o}, 16'd1);
    pulse(1, 6);
    chk("R6 chain after 11", cnt_chain_o, 16'h0000);
    chk("R6 irq1 not yet", {15'h0, irq1_o}, 16'd0);
    pulse(1, 1);
    chk("R6 chain after 12", cnt_chain_o, 16'h0203);
    chk("R6 irq1 at 12", {15'h0, irq1_o}, 16'd1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_load();
    t_run_select();
    t_underflow();
    t_set_wins();
    t_sel_off();
    t_div_change();
    t_hundred();
    t_cascade();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule